// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This unit holds a bank of hardware breakpoint slots that a debugger programs through a simple register-write port. Each slot has a 64-bit address register and a 64-bit control register. A fetch stage presents the start address of each instruction, qualified by a valid bit. One clock later the unit reports whether any armed slot matched, and if so the lowest-numbered matching slot.

Only plain address matching can fire. The type codes for linked and unlinked address match are the two that arm a slot. Every other type code never produces a hit, and neither does a slot whose enable bit is clear. The byte-lane select field in the control register is normalised on every write, so it can only hold one of four values. One of those values moves the match point up by one halfword, which covers a 16-bit instruction in the upper half of a word. The stored address is sign-extended from bit 48 and word-aligned before it is compared.

Top module: `ibrk_unit`

## Requirements
- R1: While reset is asserted and after it is released, `hit` is 0 and `hit_slot` is 0, and every address and control register reads back 0.
- R2: A slot whose control bit 0 (enable) is clear never produces a hit.
- R3: The type code in control bits [23:20] arms a slot only when it is 0 or 1. Any other code gives no hit.
- R4: On a control write, stored bit 6 takes written bit 5 and stored bit 8 takes written bit 7. All other bits are stored as written, and `rd_data` returns the stored value.
- R5: A slot compares against its address register bits [48:2], with bit 48 copied into bits [63:49] and bits [1:0] taken as zero.
- R6: A lane field (control bits [8:5]) of 0000 gives no hit. A value of 0011 or 1111 matches at the compared address. A value of 1100 matches at the compared address plus 2.
- R7: A hit needs the fetch address to equal the slot's match address exactly. Any address that only overlaps the covered range gives no hit.
- R8: A register write is used for matching from the next clock on. A fetch in the same cycle as the write still sees the old contents.
- R9: When `fetch_valid` is low, `hit` is 0 one clock later.
- R10: `hit` and `hit_slot` are registered and reflect the fetch presented one clock earlier. When several slots match, `hit_slot` is the lowest-numbered one.
- R11: `hit_slot` is 0 whenever `hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel_ctrl | input | 1 | 1 selects the control register, 0 the address register |
| wr_slot | input | 4 | Slot index for the write |
| wr_data | input | 64 | Write data |
| rd_sel_ctrl | input | 1 | 1 reads the control register, 0 the address register |
| rd_slot | input | 4 | Slot index for the read |
| rd_data | output | 64 | Stored contents of the selected register, combinational |
| fetch_valid | input | 1 | Qualifies `fetch_addr` |
| fetch_addr | input | 64 | Start address of the fetched instruction |
| hit | output | 1 | A slot matched the previous fetch |
| hit_slot | output | 4 | Lowest matching slot, 0 when there is no hit |

## Verification
The bench targets the upper-halfword lane value. A design that ignored it would fire on the word address rather than two bytes above it. Addresses with bit 48 set are used to catch a design that zero-extends instead of sign-extending, which would miss the high address and fire on the unextended one. Control writes that set only bit 5 or only bit 7 expose a design that skips lane normalisation: it would read back the raw field and mis-match. Slots with overlapping addresses and a write landing in the same cycle as a fetch show a wrong priority order or a write that takes effect a cycle too early.

// File: rtl/ibrk_unit.sv
module ibrk_unit #(
  parameter int NUM_SLOTS = 16,
  parameter int AW        = 64,
  parameter int SEXT_BIT  = 48,
  localparam int SW       = $clog2(NUM_SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel_ctrl,
  input  logic [SW-1:0] wr_slot,
  input  logic [AW-1:0] wr_data,
  input  logic          rd_sel_ctrl,
  input  logic [SW-1:0] rd_slot,
  output logic [AW-1:0] rd_data,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  output logic          hit,
  output logic [SW-1:0] hit_slot
);

  localparam int EXT_W = AW - 1 - SEXT_BIT;

  logic [AW-1:0]        val_q [NUM_SLOTS];
  logic [AW-1:0]        ctl_q [NUM_SLOTS];
  logic [AW-1:0]        wr_norm;
  logic [NUM_SLOTS-1:0] match;
  logic [SW-1:0]        slot_d;

  assign wr_norm = {wr_data[AW-1:9], wr_data[7], wr_data[7], wr_data[5], wr_data[5], wr_data[4:0]};
  assign rd_data = rd_sel_ctrl ? ctl_q[rd_slot] : val_q[rd_slot];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [3:0]    lanes;
    logic [3:0]    kind;
    logic [AW-1:0] eff;
    assign lanes = ctl_q[s][8:5];
    assign kind  = ctl_q[s][23:20];
    assign eff   = {{EXT_W{val_q[s][SEXT_BIT]}}, val_q[s][SEXT_BIT:2], lanes == 4'b1100, 1'b0};
    assign match[s] = fetch_valid && ctl_q[s][0] && (kind[3:1] == 3'b000) &&
                      (lanes != 4'b0000) && (fetch_addr == eff);
  end

  always_comb begin
    slot_d = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (match[i]) slot_d = SW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        val_q[i] <= '0;
        ctl_q[i] <= '0;
      end
      hit      <= 1'b0;
      hit_slot <= '0;
    end else begin
      if (wr_en) begin
        if (wr_sel_ctrl) ctl_q[wr_slot] <= wr_norm;
        else             val_q[wr_slot] <= wr_data;
      end
      hit      <= |match;
      hit_slot <= slot_d;
    end
  end

endmodule

module ibrk_unit_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int AW        = 64,
  localparam int SW       = $clog2(NUM_SLOTS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_valid,
  input logic          hit,
  input logic [SW-1:0] hit_slot,
  input logic          rd_sel_ctrl,
  input logic [AW-1:0] rd_data
);

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> (!hit && hit_slot == '0));

  a_r9_valid_gates_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !hit);

  a_r11_idle_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> hit_slot == '0);

  a_r4_lane_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel_ctrl |-> (rd_data[6] == rd_data[5] && rd_data[8] == rd_data[7]));

endmodule

bind ibrk_unit ibrk_unit_chk #(.NUM_SLOTS(NUM_SLOTS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .hit(hit),
  .hit_slot(hit_slot), .rd_sel_ctrl(rd_sel_ctrl), .rd_data(rd_data)
);

// File: tb/test_ibrk_unit.sv
module test_ibrk_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel_ctrl = 1'b0;
  logic [3:0]  wr_slot = '0;
  logic [63:0] wr_data = '0;
  logic        rd_sel_ctrl = 1'b0;
  logic [3:0]  rd_slot = '0;
  logic [63:0] rd_data;
  logic        fetch_valid = 1'b0;
  logic [63:0] fetch_addr = '0;
  logic        hit;
  logic [3:0]  hit_slot;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  logic [63:0] m_val [16];
  logic [63:0] m_ctl [16];
  logic        e_hit;
  logic [3:0]  e_slot;

  always #5 clk = ~clk;

  ibrk_unit i_ibrk_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel_ctrl(wr_sel_ctrl),
    .wr_slot(wr_slot), .wr_data(wr_data), .rd_sel_ctrl(rd_sel_ctrl),
    .rd_slot(rd_slot), .rd_data(rd_data), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .hit(hit), .hit_slot(hit_slot)
  );

  function automatic logic [63:0] match_addr(input logic [63:0] v, input logic [63:0] c);
    logic [63:0] a;
    a = v & 64'h0001_FFFF_FFFF_FFFC;
    if (v[48]) a = a | 64'hFFFE_0000_0000_0000;
    if (c[8:5] == 4'hC) a = a + 64'd2;
    return a;
  endfunction

  function automatic bit armed(input logic [63:0] c);
    return c[0] == 1'b1 && (c[23:20] == 4'd0 || c[23:20] == 4'd1) && c[8:5] != 4'h0;
  endfunction

  // reference model: result from current contents, then apply the write
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_val[i] = '0; m_ctl[i] = '0; end
      e_hit = 0; e_slot = 0;
    end else begin
      logic h; logic [3:0] sl;
      h = 0; sl = 0;
      if (fetch_valid)
        for (int i = 0; i < 16; i++)
          if (!h && armed(m_ctl[i]) && fetch_addr == match_addr(m_val[i], m_ctl[i])) begin
            h = 1; sl = 4'(i);
          end
      e_hit = h; e_slot = sl;
      if (wr_en) begin
        if (wr_sel_ctrl) begin
          logic [63:0] d;
          d = wr_data; d[6] = wr_data[5]; d[8] = wr_data[7];
          m_ctl[wr_slot] = d;
        end else m_val[wr_slot] = wr_data;
      end
    end
  end

  always @(negedge clk) if (!done) begin
    checks++;
    if (hit !== e_hit || hit_slot !== e_slot) begin
      errors++;
      $display("FAIL %s model: hit=%0b slot=%0d expected hit=%0b slot=%0d",
               cur_req, hit, hit_slot, e_hit, e_slot);
    end
  end

  task automatic check_out(input logic eh, input logic [3:0] es, input string req);
    checks++;
    if (hit !== eh || hit_slot !== es) begin
      errors++;
      $display("FAIL %s: hit=%0b slot=%0d expected hit=%0b slot=%0d", req, hit, hit_slot, eh, es);
    end
  endtask

  task automatic check_rd(input bit c, input int s, input logic [63:0] exp, input string req);
    rd_sel_ctrl = c; rd_slot = 4'(s);
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: read slot %0d ctrl=%0b got %h expected %h", req, s, c, rd_data, exp);
    end
  endtask

  // drive one cycle at a falling edge, return at the next falling edge
  task automatic step(input bit we, input bit sel, input int s, input logic [63:0] d,
                      input bit fv, input logic [63:0] fa);
    wr_en = we; wr_sel_ctrl = sel; wr_slot = 4'(s); wr_data = d;
    fetch_valid = fv; fetch_addr = fa;
    @(negedge clk);
    wr_en = 0; fetch_valid = 0;
  endtask

  task automatic fetch(input logic [63:0] a); step(0, 0, 0, '0, 1, a); endtask
  task automatic wr(input int s, input bit sel, input logic [63:0] d); step(1, sel, s, d, 0, '0); endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] pool [6];
    @(negedge clk); @(negedge clk);
    check_out(0, 0, "R1");
    rst_n = 1;
    @(negedge clk);
    check_out(0, 0, "R1");
    for (int s = 0; s < 16; s++) begin
      check_rd(0, s, '0, "R1");
      check_rd(1, s, '0, "R1");
    end

    cur_req = "R6";
    wr(3, 0, 64'h1000);
    wr(3, 1, 64'h1E1);
    fetch(64'h1000); check_out(1, 3, "R6 lanes 1111");
    cur_req = "R7";
    fetch(64'h1002); check_out(0, 0, "R7 overlap only");
    fetch(64'h1004); check_out(0, 0, "R7");
    cur_req = "R9";
    step(0, 0, 0, '0, 0, 64'h1000); check_out(0, 0, "R9 valid low");

    cur_req = "R4";
    wr(5, 0, 64'h0001_0000_0000_2003);
    wr(5, 1, 64'h0010_0021);
    check_rd(1, 5, 64'h0010_0061, "R4 bit5 copied");
    cur_req = "R5";
    fetch(64'hFFFF_0000_0000_2000); check_out(1, 5, "R5 sign extend");
    fetch(64'h0001_0000_0000_2000); check_out(0, 0, "R5 unextended");
    fetch(64'hFFFF_0000_0000_2003); check_out(0, 0, "R5 low bits");

    cur_req = "R6";
    wr(7, 0, 64'h3000);
    wr(7, 1, 64'h81);
    check_rd(1, 7, 64'h181, "R4 bit7 copied");
    fetch(64'h3002); check_out(1, 7, "R6 lanes 1100");
    fetch(64'h3000); check_out(0, 0, "R6 lanes 1100 base");

    wr(10, 0, 64'h4000);
    wr(10, 1, 64'h1);
    fetch(64'h4000); check_out(0, 0, "R6 lanes 0000");

    cur_req = "R2";
    wr(9, 0, 64'h5000);
    wr(9, 1, 64'h1E0);
    fetch(64'h5000); check_out(0, 0, "R2 disabled");

    cur_req = "R3";
    wr(2, 0, 64'h1000);
    wr(2, 1, 64'h0020_01E1);
    fetch(64'h1000); check_out(1, 3, "R3 type 2 ignored");
    wr(2, 1, 64'h00B0_01E1);
    fetch(64'h1000); check_out(1, 3, "R3 type 11 ignored");

    cur_req = "R8";
    step(1, 1, 2, 64'h0010_01E1, 1, 64'h1000); check_out(1, 3, "R8 same-cycle old");
    fetch(64'h1000); check_out(1, 2, "R10 lowest slot");
    step(1, 1, 2, 64'h0, 1, 64'h1000); check_out(1, 2, "R8 same-cycle old");
    fetch(64'h1000); check_out(1, 3, "R8 after write");
    wr(3, 1, 64'h0);
    fetch(64'h1000); check_out(0, 0, "R11 no hit slot zero");

    cur_req = "R10";
    pool[0] = 64'h1000; pool[1] = 64'h1002; pool[2] = 64'hFFFF_0000_0000_2000;
    pool[3] = 64'h3002; pool[4] = 64'h0001_0000_0000_2000; pool[5] = 64'h3000;
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 3) begin
        logic [63:0] c;
        c = '0;
        c[0] = $urandom_range(0, 3) != 0;
        c[23:20] = 4'($urandom_range(0, 3));
        c[8:5] = 4'($urandom_range(0, 15));
        step(1, 1, $urandom_range(0, 15), c, $urandom_range(0, 1), pool[$urandom_range(0, 5)]);
      end else if (r < 5) begin
        step(1, 0, $urandom_range(0, 15), pool[$urandom_range(0, 5)] | 64'($urandom_range(0, 3)),
             $urandom_range(0, 1), pool[$urandom_range(0, 5)]);
      end else begin
        step(0, 0, 0, '0, $urandom_range(0, 7) != 0, pool[$urandom_range(0, 5)]);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule